// File: doc/BRIEF.md
# Detection Flag Map with Read-Modify-Write Merge

This block holds a one-bit-per-cell detection map for a radar frame, stored in a single block RAM. Each cell is addressed by a range bin and a Doppler bin. A detector upstream sends strobes. Each strobe carries a flag and the two bin indices. The block merges the flag into the stored bit with a three-step read-modify-write that is not pipelined. While one merge is in flight, another strobe cannot be accepted. Such a strobe is rejected on the spot rather than queued.

When a frame ends, the block wipes the whole map so the next frame starts from zeros. It does this with a sweep that writes zero to one address per cycle, starting at address zero. A second, independent read port lets the transfer side read the map out. A same-cycle drop strobe and a sticky saturating drop counter report every rejected strobe. Tests can use them to show that a strobe cadence of three cycles is lossless and that a faster cadence loses strobes.

Top module: `det_map_rmw`

## Requirements
- R1: A strobe is accepted only when `det_valid_i` is high, `frame_done_i` is low, filling is active, no clear sweep is running and the merge engine is idle. An accepted strobe holds `rmw_busy_o` high for the two following cycles. The engine is idle again in the third cycle.
- R2: An accepted strobe replaces the stored bit with the OR of the stored bit and `det_flag_i`. A flag of 0 leaves a set bit set, and a flag of 1 sets it.
- R3: The cell address is `range_bin_i * 2**DOPP_W + dopp_bin_i`, so the Doppler bin is the low, fastest-changing part. `rd_addr_i` uses the same address, and `rd_data_o` returns the cell one cycle after the address is presented.
- R4: A valid strobe that arrives while the merge engine is busy is discarded and leaves the map unchanged. In that same cycle `drop_o` is high.
- R5: A valid strobe that arrives during a clear sweep, in the cycle `frame_done_i` is high, or in the cycle just after it, is discarded and raises `drop_o`. A clear sweep and a merge are never in flight together.
- R6: After a one-cycle `frame_done_i` pulse, filling stops for one cycle. `clearing_o` then rises in the second cycle after the pulse and stays high for exactly 2**(RANGE_W+DOPP_W) cycles, writing zero to addresses 0 upward. Afterwards every cell reads 0.
- R7: While reset is active, and just after it is released, `drop_cnt_o` is 0, `rmw_busy_o` is low and `clearing_o` is high. The clear sweep then runs for 2**(RANGE_W+DOPP_W) cycles.
- R8: `drop_cnt_o` goes up by one for each cycle in which `drop_o` is high and holds otherwise. It saturates at 2**CNT_W-1 and is cleared only by reset.
- R9: Strobes spaced three cycles apart are all accepted. Strobes spaced two cycles apart are accepted and rejected in turn, starting with an accepted one. A strobe held every cycle is accepted once in every three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| det_flag_i | input | 1 | Detection flag to merge |
| det_valid_i | input | 1 | Strobe qualifier |
| range_bin_i | input | RANGE_W | Range bin, high part of the address |
| dopp_bin_i | input | DOPP_W | Doppler bin, low part of the address |
| frame_done_i | input | 1 | Frame complete pulse; starts a clear sweep |
| rd_addr_i | input | RANGE_W+DOPP_W | Transfer-side read address |
| rd_data_o | output | 1 | Cell read one cycle after `rd_addr_i` |
| rmw_busy_o | output | 1 | Merge engine in read-wait or write-back |
| clearing_o | output | 1 | Clear sweep in progress |
| drop_o | output | 1 | A valid strobe is rejected this cycle |
| drop_cnt_o | output | CNT_W | Saturating count of rejected strobes |

## Verification
The map is tried with a 32-cell configuration. A three-cycle train covers every address with an address-dependent flag pattern; reading all cells back separates a correct address layout from a swapped one and shows that no strobe was lost. A second full pass with all flags at zero shows that the merge is an OR and not an overwrite. A two-cycle train and a strobe held every cycle check that rejected strobes are counted exactly and leave their cells untouched. Strobes placed around a frame-complete pulse and during the sweep check both rejection windows, the length of the sweep and a fully zeroed map, and the held strobe drives the counter to saturation.

// File: rtl/det_map_pkg.sv
package det_map_pkg;
  typedef enum logic [1:0] {
    RMW_IDLE    = 2'd0,
    RMW_RD_WAIT = 2'd1,
    RMW_WB      = 2'd2
  } rmw_state_e;
endpackage

// File: rtl/det_map_ram.sv
module det_map_ram #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wdata_i,
  input  logic              ra_en_i,
  input  logic [ADDR_W-1:0] ra_addr_i,
  output logic              ra_data_o,
  input  logic [ADDR_W-1:0] rb_addr_i,
  output logic              rb_data_o
);
  localparam int Depth = 1 << ADDR_W;

  logic mem [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // merge port: holds its word between reads
  always_ff @(posedge clk_i) begin
    if (ra_en_i) ra_data_o <= mem[ra_addr_i];
  end

  always_ff @(posedge clk_i) begin
    rb_data_o <= mem[rb_addr_i];
  end
endmodule

// File: rtl/det_map_clear.sv
module det_map_clear #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_done_i,
  output logic              filling_o,
  output logic              clearing_o,
  output logic [ADDR_W-1:0] clr_addr_o
);
  localparam logic [ADDR_W-1:0] LastAddr = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filling_o  <= 1'b1;
      clearing_o <= 1'b1;
      clr_addr_o <= '0;
    end else if (frame_done_i) begin
      filling_o <= 1'b0;
    end else if (!filling_o) begin
      filling_o  <= 1'b1;
      clearing_o <= 1'b1;
      clr_addr_o <= '0;
    end else if (clearing_o) begin
      if (clr_addr_o == LastAddr) clearing_o <= 1'b0;
      else                        clr_addr_o <= clr_addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/det_map_rmw_ctrl.sv
module det_map_rmw_ctrl
  import det_map_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              flag_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              enable_i,
  input  logic              old_bit_i,
  output logic              accept_o,
  output logic              drop_o,
  output logic              busy_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              wdata_o
);
  rmw_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              flag_q;

  assign accept_o = valid_i && enable_i && (state_q == RMW_IDLE);
  assign drop_o   = valid_i && !accept_o;
  assign busy_o   = (state_q != RMW_IDLE);
  assign we_o     = (state_q == RMW_WB);
  assign waddr_o  = addr_q;
  assign wdata_o  = old_bit_i | flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RMW_IDLE;
      addr_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      unique case (state_q)
        RMW_IDLE: if (accept_o) begin
          state_q <= RMW_RD_WAIT;
          addr_q  <= addr_i;
          flag_q  <= flag_i;
        end
        RMW_RD_WAIT: state_q <= RMW_WB;
        RMW_WB:      state_q <= RMW_IDLE;
        default:     state_q <= RMW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/det_map_drop_cnt.sv
module det_map_drop_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drop_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (drop_i && cnt_o != CntMax) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/det_map_rmw.sv
module det_map_rmw #(
  parameter int RANGE_W = 6,
  parameter int DOPP_W  = 5,
  parameter int CNT_W   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      det_flag_i,
  input  logic                      det_valid_i,
  input  logic [RANGE_W-1:0]        range_bin_i,
  input  logic [DOPP_W-1:0]         dopp_bin_i,
  input  logic                      frame_done_i,
  input  logic [RANGE_W+DOPP_W-1:0] rd_addr_i,
  output logic                      rd_data_o,
  output logic                      rmw_busy_o,
  output logic                      clearing_o,
  output logic                      drop_o,
  output logic [CNT_W-1:0]          drop_cnt_o
);
  localparam int AddrW = RANGE_W + DOPP_W;

  logic             filling;
  logic [AddrW-1:0] clr_addr;
  logic [AddrW-1:0] det_addr;
  logic             rmw_accept;
  logic             rmw_enable;
  logic             rmw_we;
  logic [AddrW-1:0] rmw_waddr;
  logic             rmw_wdata;
  logic             old_bit;
  logic             ram_we;
  logic [AddrW-1:0] ram_waddr;
  logic             ram_wdata;

  assign det_addr   = {range_bin_i, dopp_bin_i};
  assign rmw_enable = filling && !clearing_o && !frame_done_i;

  det_map_clear #(.ADDR_W(AddrW)) u_clear (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_done_i(frame_done_i),
    .filling_o   (filling),
    .clearing_o  (clearing_o),
    .clr_addr_o  (clr_addr)
  );

  det_map_rmw_ctrl #(.ADDR_W(AddrW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (det_valid_i),
    .flag_i   (det_flag_i),
    .addr_i   (det_addr),
    .enable_i (rmw_enable),
    .old_bit_i(old_bit),
    .accept_o (rmw_accept),
    .drop_o   (drop_o),
    .busy_o   (rmw_busy_o),
    .we_o     (rmw_we),
    .waddr_o  (rmw_waddr),
    .wdata_o  (rmw_wdata)
  );

  // sweep owns the write port; merges cannot overlap it
  assign ram_we    = clearing_o | rmw_we;
  assign ram_waddr = clearing_o ? clr_addr : rmw_waddr;
  assign ram_wdata = clearing_o ? 1'b0     : rmw_wdata;

  det_map_ram #(.ADDR_W(AddrW)) u_ram (
    .clk_i    (clk_i),
    .we_i     (ram_we),
    .waddr_i  (ram_waddr),
    .wdata_i  (ram_wdata),
    .ra_en_i  (rmw_accept),
    .ra_addr_i(det_addr),
    .ra_data_o(old_bit),
    .rb_addr_i(rd_addr_i),
    .rb_data_o(rd_data_o)
  );

  det_map_drop_cnt #(.CNT_W(CNT_W)) u_drop_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .drop_i(drop_o),
    .cnt_o (drop_cnt_o)
  );
endmodule

// File: rtl/det_map_rmw_chk.sv
module det_map_rmw_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             det_valid_i,
  input logic             frame_done_i,
  input logic             accept_i,
  input logic             busy_i,
  input logic             clearing_i,
  input logic             drop_i,
  input logic [CNT_W-1:0] drop_cnt_i
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  assert_busy_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> busy_i ##1 busy_i ##1 !busy_i);

  assert_reject_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_valid_i && busy_i) |-> (drop_i && !accept_i));

  assert_reject_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_valid_i && (clearing_i || frame_done_i)) |-> drop_i);

  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clearing_i && busy_i));

  assert_clear_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i ##1 !frame_done_i) |=> clearing_i);

  assert_cnt_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> drop_cnt_i == (($past(drop_cnt_i) == CntMax) ? CntMax
                                                           : $past(drop_cnt_i) + 1'b1));

  assert_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drop_i |=> $stable(drop_cnt_i));
endmodule

bind det_map_rmw det_map_rmw_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .det_valid_i (det_valid_i),
  .frame_done_i(frame_done_i),
  .accept_i    (rmw_accept),
  .busy_i      (rmw_busy_o),
  .clearing_i  (clearing_o),
  .drop_i      (drop_o),
  .drop_cnt_i  (drop_cnt_o)
);

// File: tb/det_map_rmw_bench.sv
module det_map_rmw_bench;
  localparam int RANGE_W = 3;
  localparam int DOPP_W  = 2;
  localparam int CNT_W   = 4;
  localparam int AW      = RANGE_W + DOPP_W;
  localparam int DEPTH   = 1 << AW;
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               flag = 1'b0;
  logic               valid = 1'b0;
  logic [RANGE_W-1:0] rbin = '0;
  logic [DOPP_W-1:0]  dbin = '0;
  logic               fdone = 1'b0;
  logic [AW-1:0]      raddr = '0;
  logic               rdata;
  logic               busy;
  logic               clearing;
  logic               drop;
  logic [CNT_W-1:0]   dcnt;

  int checks = 0;
  int failures = 0;
  int exp_drops = 0;
  bit exp_map [DEPTH];

  always #5 clk = ~clk;

  det_map_rmw #(.RANGE_W(RANGE_W), .DOPP_W(DOPP_W), .CNT_W(CNT_W)) u_det_map_rmw (
    .clk_i(clk), .rst_ni(rst_n), .det_flag_i(flag), .det_valid_i(valid),
    .range_bin_i(rbin), .dopp_bin_i(dbin), .frame_done_i(fdone),
    .rd_addr_i(raddr), .rd_data_o(rdata), .rmw_busy_o(busy),
    .clearing_o(clearing), .drop_o(drop), .drop_cnt_o(dcnt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic dump_map(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      raddr = AW'(a);
      @(negedge clk);
      check(req, int'(rdata), int'(exp_map[a]));
    end
  endtask

  // strobe train: one strobe every sp cycles, cell (i*step+off) mod DEPTH
  task automatic train(input int n, input int sp, input int step, input int off,
                       input int fmode, input string req);
    int free = 0;
    for (int c = 0; c < n * sp; c++) begin
      if (c % sp == 0) begin
        int i = c / sp;
        int a = (i * step + off) % DEPTH;
        bit f = (fmode == 0) ? 1'b0 : (fmode == 1) ? 1'b1 : bit'(a % 3 != 0);
        bit acc = (c >= free);
        rbin  = RANGE_W'(a >> DOPP_W);
        dbin  = DOPP_W'(a % (1 << DOPP_W));
        flag  = f;
        valid = 1'b1;
        #1;
        check(req, int'(drop), int'(!acc));
        if (acc) begin
          free = c + 3;
          exp_map[a] = exp_map[a] | f;
        end else exp_drops++;
      end else valid = 1'b0;
      @(negedge clk);
    end
    valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n;
    for (int a = 0; a < DEPTH; a++) exp_map[a] = 1'b0;
    @(negedge clk);
    // R7 reset state
    check("R7 clearing in reset", int'(clearing), 1);
    check("R7 busy in reset", int'(busy), 0);
    check("R7 count in reset", int'(dcnt), 0);
    rst_n = 1'b1;
    n = 0;
    while (clearing && n < 4 * DEPTH) begin n++; @(negedge clk); end
    check("R7 reset sweep length", n, DEPTH);
    check("R7 count after sweep", int'(dcnt), 0);
    dump_map("R6 map zero after reset sweep");

    // R9/R3: every cell once at 3-cycle spacing, flag depends on address
    train(DEPTH, 3, 1, 0, 2, "R9 no drop at 3-cycle spacing");
    check("R9 count after 3-cycle train", int'(dcnt), 0);
    dump_map("R3 address layout and contents");

    // R2: zero flags must not clear set bits
    train(DEPTH, 3, 5, 1, 0, "R2 zero-flag pass");
    dump_map("R2 OR merge keeps set bits");

    // R1/R4/R9: 2-cycle spacing onto cells that are still 0
    check("R1 busy idle before train", int'(busy), 0);
    train(10, 2, 3, 0, 1, "R4 drop at 2-cycle spacing");
    check("R4 count after 2-cycle train", int'(dcnt), sat(exp_drops));
    dump_map("R4 rejected strobes leave map");

    // R5/R6: strobes around a frame-complete pulse and during the sweep
    rbin = '0; dbin = '0; flag = 1'b1;
    fdone = 1'b1; valid = 1'b1;
    #1 check("R5 drop in frame_done cycle", int'(drop), 1);
    exp_drops++;
    @(negedge clk);
    fdone = 1'b0;
    #1 check("R5 drop in cycle after frame_done", int'(drop), 1);
    exp_drops++;
    check("R6 sweep not yet started", int'(clearing), 0);
    @(negedge clk);
    check("R6 sweep starts second cycle", int'(clearing), 1);
    #1 check("R5 drop during sweep", int'(drop), 1);
    exp_drops++;
    @(negedge clk);
    valid = 1'b0;
    n = 1;
    while (clearing && n < 4 * DEPTH) begin n++; @(negedge clk); end
    check("R6 sweep length", n, DEPTH);
    check("R5 count after sweep drops", int'(dcnt), sat(exp_drops));
    for (int a = 0; a < DEPTH; a++) exp_map[a] = 1'b0;
    dump_map("R6 map zero after frame sweep");

    // R9/R8: strobe held every cycle, 1 of 3 accepted, count saturates
    rbin = 3'd1; dbin = 2'd2; flag = 1'b1; valid = 1'b1;
    for (int c = 0; c < 30; c++) begin
      #1 check("R9 held strobe cadence", int'(drop), int'(c % 3 != 0));
      if (c % 3 != 0) exp_drops++;
      @(negedge clk);
    end
    valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 count saturates", int'(dcnt), sat(exp_drops));
    exp_map[1 * 4 + 2] = 1'b1;
    raddr = AW'(6);
    @(negedge clk);
    check("R2 held strobe cell set", int'(rdata), 1);
    repeat (5) @(negedge clk);
    check("R8 count sticky", int'(dcnt), CMAX);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule